// File: doc/BRIEF.md
# Total-Store-Order Store Buffer

This block is a per-core write buffer placed between the core's load/store request port and a single-ported, synchronous memory. Stores are accepted into a small FIFO and written to memory in the background, strictly oldest first. Loads do not wait for that drain. A load whose address matches a buffered store takes its data from the youngest matching entry. Any other load reads memory directly, even while older stores to other addresses are still queued. The only reordering a program can observe is therefore a later load passing an earlier store.

Besides loads and stores, the core can issue two kinds of fence and two locked read-modify-write operations: swap, and fetch-and-add. The full fence and both locked operations wait until the buffer is empty. A locked operation then does its read and its write back-to-back on the memory port, with no other request in between. The store-only fence completes at once. The FIFO already keeps stores in order, so it leaves the buffer and loads untouched.

Back-pressure rules:
- The request channel is valid/ready. A request transfers on a rising edge with both `req_valid` and `req_ready` high. `req_ready` depends on the current state and on `req_op`, never on `req_valid`.
- The response channel has no ready. Only one load or locked operation is ever outstanding, so the core must take `rsp_data` in the one cycle `rsp_valid` is high.
- On the memory side, a request transfers when `mem_valid` and `mem_ready` are both high. Read data returns later, marked by a single-cycle `mem_rvalid`.

Top module: `tso_store_buffer`

## Requirements
- R1: Every accepted store is written to memory exactly once, with unchanged address and data, in the order the stores were accepted.
- R2: A store request is accepted only while fewer than DEPTH entries are buffered. With DEPTH entries buffered, `req_ready` is low for `req_op` = 1 (store).
- R3: A load (`req_op` = 0) that matches no buffered address reads memory and returns the memory word. It may complete while older stores to other addresses remain buffered and unwritten.
- R4: A load that matches one or more buffered addresses returns the data of the youngest matching entry. `rsp_valid` rises in the cycle after acceptance, and no memory read is issued.
- R5: Loads complete one at a time and in order. While a load or locked operation is outstanding, `req_ready` stays low for every opcode.
- R6: A full fence (`req_op` = 2) is accepted only when the buffer is empty, so every older store has reached memory before any later request is taken.
- R7: A store-only fence (`req_op` = 3) is accepted at once in the idle state whatever the buffer holds. It leaves the buffered entries and load forwarding unchanged. Codes 6 and 7 behave the same way.
- R8: A swap (`req_op` = 4) is accepted only with an empty buffer. It returns the old memory word and leaves the operand in memory.
- R9: A fetch-and-add (`req_op` = 5) is accepted only with an empty buffer. It returns the old word and leaves old + operand, modulo 2^64, in memory.
- R10: After reset the buffer is empty, `rsp_valid` and `mem_valid` are low, and `req_ready` is high for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can take the presented request |
| req_op | input | 3 | 0 load, 1 store, 2 full fence, 3 store fence, 4 swap, 5 fetch-add |
| req_addr | input | AW | Word address (64-bit aligned) |
| req_data | input | DW | Store data or read-modify-write operand |
| rsp_valid | output | 1 | Load / locked-op result valid for one cycle |
| rsp_data | output | DW | Loaded or old value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The bench builds the block with DEPTH = 4, AW = 32 and DW = 64, over a sixteen-word address window. With so few entries, the random mix fills the buffer often, wraps the FIFO pointers many times, and often leaves several entries for one address, so youngest-match selection gets real competition. A memory model that can refuse writes while still serving reads holds stores in the buffer on purpose. That exposes load bypass, the full condition and fence stalling in a controlled way.

// File: rtl/tso_sb_pkg.sv
`timescale 1ns/1ps
package tso_sb_pkg;
  typedef enum logic [2:0] {
    OP_LOAD      = 3'd0,
    OP_STORE     = 3'd1,
    OP_FENCE_ALL = 3'd2,
    OP_FENCE_ST  = 3'd3,
    OP_SWAP      = 3'd4,
    OP_ADD       = 3'd5
  } sb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LD_REQ,
    ST_LD_WAIT,
    ST_RMW_RD,
    ST_RMW_WAIT,
    ST_RMW_WR
  } sb_state_e;
endpackage

// File: rtl/sb_fifo.sv
`timescale 1ns/1ps
// Ordered store queue with youngest-match lookup for load forwarding.
module sb_fifo #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] occ,
  output logic          empty,
  output logic          full,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [DW-1:0] lk_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [PW-1:0] age [DEPTH];
  logic [DEPTH-1:0] match;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      if (pop)  rd_ptr <= rd_ptr + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // One comparator per slot; a slot is live when its age is below the count.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign age[g]   = PW'(g) - rd_ptr;
    assign match[g] = ({1'b0, age[g]} < cnt) && (addr_q[g] == lk_addr);
  end

  // Walk from oldest to youngest so the youngest match wins.
  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int a = 0; a < DEPTH; a++) begin
      logic [PW-1:0] ix;
      ix = rd_ptr + PW'(a);
      if (match[ix]) begin
        lk_hit  = 1'b1;
        lk_data = data_q[ix];
      end
    end
  end

  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign occ       = cnt;
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));
endmodule

// File: rtl/sb_rmw_alu.sv
`timescale 1ns/1ps
// New value for a locked read-modify-write.
module sb_rmw_alu #(
  parameter int DW = 64
) (
  input  logic          is_add,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] new_val
);
  assign new_val = is_add ? (old_val + operand) : operand;
endmodule

// File: rtl/tso_store_buffer.sv
`timescale 1ns/1ps
module tso_store_buffer
  import tso_sb_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH) + 1;

  sb_state_e     state;
  sb_op_e        op;
  logic          accept, push, pop, drain_ok;
  logic          empty, full, lk_hit;
  logic [CW-1:0] occ;
  logic [AW-1:0] head_addr, addr_q;
  logic [DW-1:0] head_data, lk_data, operand_q, old_q, new_val;
  logic          add_q, busy, rmw_wr;

  assign op     = sb_op_e'(req_op);
  assign accept = req_valid && req_ready;
  assign push   = accept && (op == OP_STORE);
  assign busy   = (state != ST_IDLE);
  assign rmw_wr = (state == ST_RMW_WR);

  always_comb begin
    req_ready = 1'b0;
    if (state == ST_IDLE) begin
      case (op)
        OP_STORE:                       req_ready = !full;
        OP_FENCE_ALL, OP_SWAP, OP_ADD:  req_ready = empty;
        default:                        req_ready = 1'b1;
      endcase
    end
  end

  sb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(req_addr), .push_data(req_data),
    .pop(pop), .head_addr(head_addr), .head_data(head_data),
    .occ(occ), .empty(empty), .full(full),
    .lk_addr(req_addr), .lk_hit(lk_hit), .lk_data(lk_data)
  );

  sb_rmw_alu #(.DW(DW)) u_alu (
    .is_add(add_q), .old_val(old_q), .operand(operand_q), .new_val(new_val)
  );

  // Memory port: reads for loads and locked ops own it; otherwise drain.
  assign drain_ok = (state == ST_IDLE) || (state == ST_LD_WAIT);
  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = new_val;
    case (state)
      ST_LD_REQ, ST_RMW_RD: mem_valid = 1'b1;
      ST_RMW_WR: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
      end
      ST_IDLE, ST_LD_WAIT: begin
        mem_valid = !empty;
        mem_we    = 1'b1;
        mem_addr  = head_addr;
        mem_wdata = head_data;
      end
      default: ;
    endcase
  end
  assign pop = drain_ok && !empty && mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      addr_q    <= '0;
      operand_q <= '0;
      old_q     <= '0;
      add_q     <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept && op == OP_LOAD) begin
            if (lk_hit) begin
              rsp_valid <= 1'b1;
              rsp_data  <= lk_data;
            end else begin
              addr_q <= req_addr;
              state  <= ST_LD_REQ;
            end
          end else if (accept && (op == OP_SWAP || op == OP_ADD)) begin
            addr_q    <= req_addr;
            operand_q <= req_data;
            add_q     <= (op == OP_ADD);
            state     <= ST_RMW_RD;
          end
        end
        ST_LD_REQ:   if (mem_ready) state <= ST_LD_WAIT;
        ST_LD_WAIT: begin
          if (mem_rvalid) begin
            rsp_valid <= 1'b1;
            rsp_data  <= mem_rdata;
            state     <= ST_IDLE;
          end
        end
        ST_RMW_RD:   if (mem_ready) state <= ST_RMW_WAIT;
        ST_RMW_WAIT: begin
          if (mem_rvalid) begin
            old_q <= mem_rdata;
            state <= ST_RMW_WR;
          end
        end
        ST_RMW_WR: begin
          if (mem_ready) begin
            rsp_valid <= 1'b1;
            rsp_data  <= old_q;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tso_sb_checker.sv
`timescale 1ns/1ps
module tso_sb_checker
  import tso_sb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [2:0]    req_op,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [CW-1:0] occ,
  input logic          busy,
  input logic          rmw_wr
);
  logic acc, drain, st_push;
  assign acc     = req_valid && req_ready;
  assign st_push = acc && (req_op == OP_STORE);
  assign drain   = mem_valid && mem_ready && mem_we && !rmw_wr;

  a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    st_push |-> (occ < CW'(DEPTH)));

  a_r6_fence_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op == OP_FENCE_ALL) |-> (occ == '0));

  a_r8_rmw_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (req_op == OP_SWAP || req_op == OP_ADD)) |-> (occ == '0));

  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  a_r1_drain_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (drain && !st_push) |=> (occ == $past(occ) - CW'(1)));
endmodule

bind tso_store_buffer tso_sb_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_we(mem_we), .occ(occ), .busy(busy), .rmw_wr(rmw_wr)
);

// File: tb/tso_store_buffer_bench.sv
`timescale 1ns/1ps
module tso_store_buffer_bench;
  localparam int DEPTH = 4;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam logic [2:0] K_LOAD = 3'd0, K_STORE = 3'd1, K_FALL = 3'd2,
                         K_FST = 3'd3, K_SWAP = 3'd4, K_ADD = 3'd5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [2:0] req_op = K_STORE;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic rsp_valid;
  logic [DW-1:0] rsp_data;
  logic mem_valid, mem_ready, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_rvalid = 0;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0, errors = 0, cyc = 0, n_wr = 0, n_rd = 0;
  logic [DW-1:0] mem_q [16];
  logic [DW-1:0] view [16];
  logic [AW-1:0] sq_a [$];
  logic [DW-1:0] sq_d [$];
  logic rnd_ok = 0, block_w = 0;

  always #10 clk = ~clk;

  tso_store_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_tso_store_buffer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Memory model: writes may be refused while reads are served.
  assign mem_ready = rnd_ok && !(block_w && mem_we);
  always @(negedge clk) rnd_ok <= ($urandom % 10) < 7;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_valid && mem_ready) begin
      if (mem_we) begin
        n_wr++;
        mem_q[mem_addr[6:3]] <= mem_wdata;
        if (sq_a.size() > 0) begin
          chk(mem_addr == sq_a[0] && mem_wdata == sq_d[0], "R1 drain order",
              {mem_addr, mem_wdata[31:0]}, {sq_a[0], sq_d[0][31:0]});
          void'(sq_a.pop_front());
          void'(sq_d.pop_front());
        end
      end else begin
        n_rd++;
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_q[mem_addr[6:3]];
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog R5 actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [AW-1:0] wa(int i);
    return AW'(i) << 3;
  endfunction

  task automatic issue(logic [2:0] op, int idx, logic [DW-1:0] d);
    bit r;
    req_valid = 1; req_op = op; req_addr = wa(idx); req_data = d;
    forever begin
      #1 r = req_ready;
      @(posedge clk);
      @(negedge clk);
      if (r) break;
    end
    req_valid = 0;
  endtask

  task automatic do_store(int idx, logic [DW-1:0] d);
    issue(K_STORE, idx, d);
    sq_a.push_back(wa(idx));
    sq_d.push_back(d);
    view[idx] = d;
  endtask

  task automatic do_load(int idx, string tag);
    bit stalled_ok = 1;
    bit waited = 0;
    issue(K_LOAD, idx, '0);
    while (!rsp_valid) begin
      waited = 1;
      if (req_ready) stalled_ok = 0;
      @(negedge clk);
    end
    chk(rsp_data == view[idx], tag, rsp_data, view[idx]);
    if (waited) chk(stalled_ok, "R5 ready low while load outstanding", 64'(stalled_ok), 1);
  endtask

  task automatic do_rmw(bit add, int idx, logic [DW-1:0] d, string tag);
    logic [DW-1:0] exp_old;
    exp_old = view[idx];
    issue(add ? K_ADD : K_SWAP, idx, d);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_data == exp_old, tag, rsp_data, exp_old);
    view[idx] = add ? exp_old + d : d;
  endtask

  initial begin
    int w0, r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      mem_q[i] = 64'h1000_0000_0000_0000 + 64'(i) * 64'h111;
      view[i]  = mem_q[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R10 reset state
    chk(req_ready && !rsp_valid && !mem_valid, "R10 reset state",
        {61'd0, req_ready, rsp_valid, mem_valid}, 64'd4);
    @(negedge clk);

    // R3: stores held back, load to another address reads memory
    block_w = 1;
    do_store(8, 64'hAAAA_0001);
    do_store(9, 64'hBBBB_0002);
    w0 = n_wr;
    do_load(2, "R3 bypass load");
    chk(n_wr == w0 && sq_a.size() == 2, "R3 stores still buffered", 64'(n_wr), 64'(w0));
    // R4: forwarding, immediate response, no memory read
    r0 = n_rd;
    issue(K_LOAD, 8, '0);
    chk(rsp_valid == 1'b1, "R4 hit latency", 64'(rsp_valid), 1);
    chk(rsp_data == 64'hAAAA_0001 && n_rd == r0, "R4 hit data no read", rsp_data, 64'hAAAA_0001);
    // R2: fill, youngest entry for same address
    do_store(8, 64'hCCCC_0003);
    do_store(8, 64'hDDDD_0004);
    req_op = K_STORE;
    #1 chk(req_ready == 1'b0, "R2 ready low when full", 64'(req_ready), 0);
    @(negedge clk);
    // R7: store fence accepted while full, forwarding unchanged
    issue(K_FST, 0, '0);
    chk(sq_a.size() == DEPTH && n_wr == w0, "R7 store fence no drain", 64'(n_wr), 64'(w0));
    r0 = n_rd;
    issue(K_LOAD, 8, '0);
    chk(rsp_valid && rsp_data == 64'hDDDD_0004 && n_rd == r0, "R4 youngest match",
        rsp_data, 64'hDDDD_0004);
    // R6: full fence waits for drain
    req_op = K_FALL;
    repeat (3) @(negedge clk);
    #1 chk(req_ready == 1'b0, "R6 fence stalls with stores", 64'(req_ready), 0);
    @(negedge clk);
    block_w = 0;
    issue(K_FALL, 0, '0);
    chk(sq_a.size() == 0 && n_wr == w0 + DEPTH, "R6 all stores written",
        64'(n_wr), 64'(w0 + DEPTH));
    do_load(8, "R1 memory holds youngest");
    // R8 swap
    do_rmw(0, 3, 64'h5555_6666_7777_8888, "R8 swap old value");
    do_load(3, "R8 swap new value");
    // R9 fetch-add with wrap
    do_store(4, '1);
    do_rmw(1, 4, 64'd2, "R9 add old value");
    do_load(4, "R9 add wraps");
    chk(view[4] == 64'd1, "R9 expected wrap", view[4], 64'd1);

    // Random mix
    for (int n = 0; n < 600; n++) begin
      int sel, idx;
      sel = $urandom % 100;
      idx = $urandom % 16;
      if (sel < 38) do_store(idx, {$urandom, $urandom});
      else if (sel < 74) do_load(idx, "R3 R4 random load");
      else if (sel < 80) issue(K_FALL, 0, '0);
      else if (sel < 86) issue((sel & 1) ? K_FST : 3'd6, 0, '0);
      else if (sel < 93) do_rmw(0, idx, {$urandom, $urandom}, "R8 random swap");
      else do_rmw(1, idx, {$urandom, $urandom}, "R9 random add");
    end
    issue(K_FALL, 0, '0);
    for (int i = 0; i < 16; i++)
      chk(mem_q[i] == view[i], "R1 final memory image", mem_q[i], view[i]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule